// File: doc/BRIEF.md
# Half-Integer Predivided Pixel Clock Generator

This block derives a pixel-rate timing signal from one of three source clock enables, all inside a single fast reference clock domain. Each source arrives as a stream of single-cycle ticks at twice its nominal frequency. The selected stream first passes through a predivider that keeps one tick out of every 4, 5 or 6. Counted against the doubled source rate, that gives ratios of 2, 2.5 or 3. A post-divider with a range of 2 to 127 follows.

The block has two outputs. The first is a one-cycle enable pulse per output period. The second is a registered square wave that is high for the first half of each period.

Software writes a 15-bit configuration word through a write strobe, and a separate enable input gates the whole generator. A written configuration is held as pending while the generator runs. It replaces the whole active setting only at the next output period boundary, so no runt period is produced. When the generator is idle, a written configuration is taken at once.

Top module: `hpclk_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, pix_tick_o and pix_clk_o are low.
- R2: In steady state, the spacing between pix_tick_o pulses is div × (code+3) ticks of the selected source.
- R3: The predivider code sits in cfg_i[8:7]. Codes 1, 2 and 3 keep one source tick in 4, 5 and 6 respectively.
- R4: The integer divider sits in cfg_i[6:0]. All values from 2 to 127 are honoured, including both ends.
- R5: The source is chosen by cfg_i[14] and cfg_i[13]. When cfg_i[14] is 0, src_tick_i[0] is used. When cfg_i[14] is 1, cfg_i[13]=0 selects src_tick_i[1] and cfg_i[13]=1 selects src_tick_i[2].
- R6: Within each period, pix_clk_o rises together with pix_tick_o. It stays high for ceil(div/2) predivided intervals and is low for the rest of the period.
- R7: If en_i is low at a clock edge, both outputs are low in the following cycle. They remain low for as long as en_i stays low.
- R8: An active configuration with div below 2, or with code 0, keeps both outputs low.
- R9: A configuration written while the generator runs becomes active only at the next period boundary. The period in which the write happens keeps its old length.
- R10: cfg_i[12:9] has no effect on the output.
- R11: pix_tick_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 3 | Doubled-rate tick per source: [0] external, [1] PLL1, [2] PLL2 |
| en_i | input | 1 | Output enable |
| cfg_wr_i | input | 1 | Strobe that loads cfg_i as the pending configuration |
| cfg_i | input | 15 | Configuration word (select, predivider code, divider) |
| pix_tick_o | output | 1 | One-cycle pulse per output period |
| pix_clk_o | output | 1 | Registered square-wave output |

## Verification
The assertions take two things for granted. First, each source tick is a single-cycle pulse sampled on clk_i. Second, en_i and cfg_i are synchronous to clk_i. Given those, the spacing and gating properties can be related directly to the registered predivider and boundary signals.

The stimulus drives every input on the falling edge. It produces the sources from free-running counters with fixed spacings: every third cycle, every second cycle, and every cycle. Configuration writes are single-cycle strobes issued from tasks. Period and duty measurements skip the first period after any change, so that the clearing of the predivider at the boundary does not enter the expected values.

// File: rtl/hpclk_pkg.sv
package hpclk_pkg;
  localparam int N_SRC  = 3;
  localparam int SRC_W  = $clog2(N_SRC);
  localparam int DIV_W  = 7;
  localparam int CODE_W = 2;
  localparam int RSV_W  = 4;
  localparam int CFG_W  = 2 + RSV_W + CODE_W + DIV_W;
  localparam int PRE_W  = 3;
  localparam int PRE_BIAS = 3;

  typedef struct packed {
    logic              ext_sel;
    logic              pll_sel;
    logic [RSV_W-1:0]  rsvd;
    logic [CODE_W-1:0] code;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  function automatic logic cfg_valid(cfg_t c);
    return (c.code != '0) && (c.div >= DIV_W'(2));
  endfunction

  // predivider length in doubled-rate ticks
  function automatic logic [PRE_W-1:0] pre_len(cfg_t c);
    return PRE_W'(c.code) + PRE_W'(PRE_BIAS);
  endfunction

  function automatic logic [SRC_W-1:0] src_idx(cfg_t c);
    if (!c.ext_sel) return SRC_W'(0);
    return c.pll_sel ? SRC_W'(2) : SRC_W'(1);
  endfunction
endpackage

// File: rtl/hpclk_cfg_ctrl.sv
module hpclk_cfg_ctrl
  import hpclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             en_i,
  input  logic             wrap_i,
  output cfg_t             act_o,
  output logic             run_o,
  output logic             apply_o
);
  cfg_t pend_q, act_q;
  logic dirty_q;

  assign run_o   = en_i && cfg_valid(act_q);
  // swap only at a period boundary, or at once when idle
  assign apply_o = dirty_q && (wrap_i || !run_o);
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      act_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (apply_o) act_q <= pend_q;
      if (cfg_wr_i) begin
        pend_q  <= cfg_t'(cfg_i);
        dirty_q <= 1'b1;
      end else if (apply_o) begin
        dirty_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpclk_prediv.sv
module hpclk_prediv
  import hpclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] len_i,
  output logic             pre_tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pre_tick_o <= 1'b0;
    end else if (!run_i || clr_i) begin
      cnt_q      <= '0;
      pre_tick_o <= 1'b0;
    end else if (tick_i) begin
      cnt_q      <= last ? '0 : cnt_q + 1'b1;
      pre_tick_o <= last;
    end else begin
      pre_tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hpclk_postdiv.sv
module hpclk_postdiv
  import hpclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             wrap_o,
  output logic             tick_o,
  output logic             sq_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nx;
  logic [DIV_W:0]   hi_len;

  assign wrap_o = run_i && pre_tick_i && (cnt_q == div_i - 1'b1);
  assign cnt_nx = wrap_o ? '0 : cnt_q + 1'b1;
  assign hi_len = ({1'b0, div_i} + 1'b1) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
      sq_o   <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
      sq_o   <= 1'b0;
    end else if (pre_tick_i) begin
      cnt_q  <= cnt_nx;
      tick_o <= wrap_o;
      sq_o   <= ({1'b0, cnt_nx} < hi_len);
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hpclk_gen.sv
module hpclk_gen
  import hpclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic             en_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             pix_tick_o,
  output logic             pix_clk_o
);
  cfg_t             act_cfg;
  logic             run, apply, wrap, pre_tick, sel_tick;
  logic [N_SRC-1:0] src_gate;

  hpclk_cfg_ctrl u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_wr_i(cfg_wr_i),
    .cfg_i   (cfg_i),
    .en_i    (en_i),
    .wrap_i  (wrap),
    .act_o   (act_cfg),
    .run_o   (run),
    .apply_o (apply)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_gate[g] = src_tick_i[g] && (src_idx(act_cfg) == SRC_W'(g));
  end
  assign sel_tick = |src_gate;

  hpclk_prediv u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clr_i     (apply),
    .tick_i    (sel_tick),
    .len_i     (pre_len(act_cfg)),
    .pre_tick_o(pre_tick)
  );

  hpclk_postdiv u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .pre_tick_i(pre_tick),
    .div_i     (act_cfg.div),
    .wrap_o    (wrap),
    .tick_o    (pix_tick_o),
    .sq_o      (pix_clk_o)
  );
endmodule

// File: rtl/hpclk_gen_chk.sv
module hpclk_gen_chk
  import hpclk_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pix_tick_o,
  input logic pix_clk_o,
  input logic run_i,
  input logic wrap_i,
  input logic pre_tick_i,
  input logic sel_tick_i,
  input cfg_t act_i
);
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pix_tick_o && !pix_clk_o)); // R7
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_tick_o |=> !pix_tick_o); // R11
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(act_i)); // R9
  AST_INVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid(act_i) |=> !pix_tick_o); // R8
  AST_PRE_FROM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_i |-> $past(sel_tick_i)); // R2
  AST_TICK_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_tick_o |-> $past(wrap_i)); // R2
endmodule

bind hpclk_gen hpclk_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .pix_tick_o(pix_tick_o),
  .pix_clk_o (pix_clk_o),
  .run_i     (run),
  .wrap_i    (wrap),
  .pre_tick_i(pre_tick),
  .sel_tick_i(sel_tick),
  .act_i     (act_cfg)
);

// File: tb/hpclk_gen_bench.sv
module hpclk_gen_bench;
  import hpclk_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 5000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_SRC-1:0] src_tick = '0;
  logic             en, cfg_wr;
  logic [CFG_W-1:0] cfg;
  logic             pix_tick, pix_clk;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;
  int               c0 = 0, c1 = 0;

  hpclk_gen u_hpclk_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .src_tick_i(src_tick),
    .en_i      (en),
    .cfg_wr_i  (cfg_wr),
    .cfg_i     (cfg),
    .pix_tick_o(pix_tick),
    .pix_clk_o (pix_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external every 3 cycles, PLL1 every 2, PLL2 every cycle
  always @(negedge clk) begin
    c0 = (c0 == 2) ? 0 : c0 + 1;
    c1 = (c1 == 1) ? 0 : c1 + 1;
    src_tick <= {1'b1, c1 == 0, c0 == 0};
  end

  function automatic logic [CFG_W-1:0] mk(bit es, bit ps, logic [3:0] rs,
                                          logic [1:0] code, logic [6:0] div);
    return {es, ps, rs, code, div};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg    = v;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_tick(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      if (pix_tick) begin ok = 1'b1; break; end
    end
  endtask

  // skip one tick, then measure a full period and its high time
  task automatic measure(output int per, output int hi);
    bit ok;
    per = -1; hi = -1;
    wait_tick(ok);
    if (ok) wait_tick(ok);
    if (!ok) return;
    hi  = pix_clk ? 1 : 0;
    per = 0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      per++;
      if (pix_tick) return;
      if (pix_clk) hi++;
    end
    per = -1;
  endtask

  task automatic run_case(string req, logic [CFG_W-1:0] v, int src_per);
    int per, hi, div, len, exp_per, exp_hi;
    div = int'(v[6:0]);
    len = int'(v[8:7]) + 3;
    exp_per = div * len * src_per;
    exp_hi  = ((div + 1) / 2) * len * src_per;
    write_cfg(v);
    measure(per, hi);
    chk(per == exp_per, req, per, exp_per);
    chk(hi == exp_hi, {req, " R6 duty"}, hi, exp_hi);
  endtask

  task automatic t_reset;
    chk(!pix_tick && !pix_clk, "R1 in reset", {pix_tick, pix_clk}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_tick && !pix_clk, "R1 after release", {pix_tick, pix_clk}, 0);
  endtask

  task automatic t_ratio;  // R2 R3 via PLL1
    en = 1'b1;
    for (int code = 1; code <= 3; code++)
      run_case("R2 R3 predivider", mk(1, 0, 0, 2'(code), 7'd5), 2);
  endtask

  task automatic t_divs;  // R4 divider ends and odd value, external source
    run_case("R4 div 2", mk(0, 0, 0, 2'd2, 7'd2), 3);
    run_case("R4 div 3", mk(0, 0, 0, 2'd1, 7'd3), 3);
    run_case("R4 div 127", mk(0, 0, 0, 2'd3, 7'd127), 3);
  endtask

  task automatic t_select;  // R5
    run_case("R5 ext with pll_sel set", mk(0, 1, 0, 2'd1, 7'd4), 3);
    run_case("R5 pll2", mk(1, 1, 0, 2'd1, 7'd4), 1);
    run_case("R5 pll1", mk(1, 0, 0, 2'd1, 7'd4), 2);
  endtask

  task automatic t_reserved;  // R10
    run_case("R10 reserved bits set", mk(1, 1, 4'hF, 2'd2, 7'd4), 1);
  endtask

  task automatic t_invalid;  // R8
    int ticks, highs;
    for (int k = 0; k < 2; k++) begin
      write_cfg(k == 0 ? mk(1, 1, 0, 2'd1, 7'd1) : mk(1, 1, 0, 2'd0, 7'd5));
      repeat (200) @(negedge clk);
      ticks = 0; highs = 0;
      repeat (500) begin
        @(negedge clk);
        ticks += int'(pix_tick);
        highs += int'(pix_clk);
      end
      chk(ticks == 0, "R8 invalid ticks", ticks, 0);
      chk(highs == 0, "R8 invalid clk high", highs, 0);
    end
  endtask

  task automatic t_enable;  // R7
    int ticks, highs, per, hi;
    write_cfg(mk(1, 1, 0, 2'd1, 7'd3));
    measure(per, hi);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!pix_tick && !pix_clk, "R7 next cycle idle", {pix_tick, pix_clk}, 0);
    ticks = 0; highs = 0;
    repeat (300) begin
      @(negedge clk);
      ticks += int'(pix_tick);
      highs += int'(pix_clk);
    end
    chk(ticks == 0 && highs == 0, "R7 stays idle", ticks + highs, 0);
    en = 1'b1;
    measure(per, hi);
    chk(per == 12, "R7 resume period", per, 12);
  endtask

  task automatic t_boundary;  // R9
    int per, hi;
    bit ok;
    run_case("R9 old setting", mk(0, 0, 0, 2'd3, 7'd20), 3);
    wait_tick(ok);
    per = 0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      per++;
      if (per == 50) begin cfg = mk(1, 1, 0, 2'd1, 7'd2); cfg_wr = 1'b1; end
      else cfg_wr = 1'b0;
      if (pix_tick) break;
    end
    chk(per == 360, "R9 period of write keeps old length", per, 360);
    measure(per, hi);
    chk(per == 8, "R9 new setting after boundary", per, 8);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; cfg_wr = 1'b0; cfg = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_ratio();
    t_divs();
    t_select();
    t_reserved();
    t_invalid();
    t_enable();
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule